// File: doc/BRIEF.md
# Serial Stream Input with Free-Space Request

This block is the receive side of a slave-only serial link that carries a compressed audio stream into a decoder. An external host drives a bit clock and a data line. A frame-select line marks which bits belong to the stream, and the frames are bytes. The block samples these asynchronous pins in its own system clock domain and rebuilds each byte. It then places the byte in an internal byte FIFO, and the decoder core drains that FIFO through a simple read port.

Flow control is a single request output. It is high only while the FIFO has room for a whole burst of bytes, so the host may send a full burst without checking again between bytes. Three static configuration inputs set the sampling edge of the bit clock, the order of the bits in each byte, and a shared-select mode. In shared-select mode the data frame is taken as the inverse of the command-select pin, which saves one wire.

Top module: `sdi_stream_in`

## Requirements
- R1: Bits are taken only from edges of the external bit clock `sclk_i` while the stream is selected. With shared mode off, the stream is selected while `dsel_n_i` is low. Clock edges while the stream is deselected never form a byte.
- R2: With `cfg_fall_edge_i` = 0 the data line is sampled on rising edges of `sclk_i`. With `cfg_fall_edge_i` = 1 it is sampled on falling edges.
- R3: With `cfg_lsb_first_i` = 0 the first bit of a byte lands in bit 7 of the stored byte. With `cfg_lsb_first_i` = 1 the first bit lands in bit 0.
- R4: Deselecting the stream clears the bit counter and discards any partial byte. The next byte starts at the first sampling edge after the stream is selected again.
- R5: `dreq_o` is high exactly when the FIFO holds at most DEPTH-WINDOW bytes, which is 32 of 64 by default. It is a registered output in the system clock domain.
- R6: A byte whose bits arrive while `dreq_o` is low is still completed and stored if the FIFO has room.
- R7: With `cfg_shared_sel_i` = 1 the stream is selected while `csel_n_i` is high, and `dsel_n_i` has no effect.
- R8: A byte that completes while the FIFO holds DEPTH bytes is dropped. The bytes already stored are left unchanged.
- R9: `overflow_o` rises on the first dropped byte and stays high until reset.
- R10: `rd_valid_o` is high while the FIFO is not empty, and `rd_data_o` shows the oldest byte. A high `rd_en_i` at a clock edge removes that byte. Bytes leave in arrival order, and a read of an empty FIFO has no effect.
- R11: After reset the FIFO is empty, `dreq_o` is high and `overflow_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External serial bit clock (asynchronous) |
| sdata_i | input | 1 | Serial data line |
| dsel_n_i | input | 1 | Data frame select, active low |
| csel_n_i | input | 1 | Command select, active low; gives the data frame in shared mode |
| cfg_fall_edge_i | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_lsb_first_i | input | 1 | 0: first bit is bit 7, 1: first bit is bit 0 |
| cfg_shared_sel_i | input | 1 | 1: data frame is the inverse of command select |
| rd_en_i | input | 1 | Pop the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte |
| rd_valid_o | output | 1 | FIFO not empty |
| dreq_o | output | 1 | Free space covers a full burst |
| overflow_o | output | 1 | Sticky flag for a dropped byte |

## Verification
The bench changes the data line between the sampling edge and the opposite edge. A design that sampled on the wrong edge would therefore store inverted bits rather than the right byte by chance. A partial byte followed by a reselect exposes a bit counter that is not cleared: the next byte would be stored shifted, or merged with the stale bits. The bench fills the FIFO to exactly 32 and 33 bytes to catch an off-by-one in the request threshold. It then fills to 64 and sends one more byte, so a design that overwrote a stored byte, wrapped its pointers early or cleared the overflow flag would return the wrong data on drain or a low flag.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Shift one serial bit into a partially built byte in the selected order
    function automatic byte_t take_bit(byte_t sh, logic b, logic lsb_first);
        if (lsb_first) begin
            return {b, sh[BYTE_W-1:1]};
        end
        return {sh[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sdi_deser.sv
module sdi_deser
    import sdi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_s,
    input  logic  sdata_s,
    input  logic  sel_act,
    input  logic  fall_edge,
    input  logic  lsb_first,
    output logic  byte_vld_o,
    output byte_t byte_o
);

    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        byte_t            sh;
        logic             sclk_prev;
        logic             vld;
        byte_t            dout;
    } deser_t;

    localparam deser_t DESER_RST = '{cnt: '0, sh: '0, sclk_prev: 1'b0,
                                     vld: 1'b0, dout: '0};

    deser_t st_d, st_q;
    logic   hit;
    byte_t  nxt;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = sclk_s;
        hit = fall_edge ? (st_q.sclk_prev & ~sclk_s) : (~st_q.sclk_prev & sclk_s);
        nxt = take_bit(st_q.sh, sdata_s, lsb_first);
        if (!sel_act) begin
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (hit) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.vld  = 1'b1;
                st_d.dout = nxt;
                st_d.cnt  = '0;
                st_d.sh   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
                st_d.sh  = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DESER_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld_o = st_q.vld;
    assign byte_o     = st_q.dout;

endmodule

// File: rtl/sdi_fifo.sv
module sdi_fifo
    import sdi_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WINDOW = 32,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  byte_t         wr_data_i,
    input  logic          rd_i,
    output byte_t         rd_data_o,
    output logic          rd_valid_o,
    output logic          dreq_o,
    output logic          ovf_o,
    output logic [CW-1:0] level_o
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] REQ_LVL  = CW'(DEPTH - WINDOW);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] level;
        logic          dreq;
        logic          ovf;
    } fifo_t;

    localparam fifo_t FIFO_RST = '{wptr: '0, rptr: '0, level: '0,
                                   dreq: (DEPTH >= WINDOW), ovf: 1'b0};

    fifo_t st_d, st_q;
    byte_t mem [DEPTH];
    logic  push, pop, full;

    always_comb begin
        st_d = st_q;
        full = (st_q.level == FULL_LVL);
        push = wr_i & ~full;
        pop  = rd_i & (st_q.level != '0);
        if (push) begin
            st_d.wptr = (st_q.wptr == LAST_PTR) ? '0 : st_q.wptr + AW'(1);
        end
        if (pop) begin
            st_d.rptr = (st_q.rptr == LAST_PTR) ? '0 : st_q.rptr + AW'(1);
        end
        st_d.level = st_q.level + CW'(push) - CW'(pop);
        st_d.ovf   = st_q.ovf | (wr_i & full);
        st_d.dreq  = (st_d.level <= REQ_LVL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FIFO_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[st_q.wptr] <= wr_data_i;
        end
    end

    assign rd_data_o  = mem[st_q.rptr];
    assign rd_valid_o = (st_q.level != '0);
    assign dreq_o     = st_q.dreq;
    assign ovf_o      = st_q.ovf;
    assign level_o    = st_q.level;

endmodule

// File: rtl/sdi_stream_in.sv
module sdi_stream_in
    import sdi_pkg::*;
#(
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned WINDOW      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              dsel_n_i,
    input  logic              csel_n_i,
    input  logic              cfg_fall_edge_i,
    input  logic              cfg_lsb_first_i,
    input  logic              cfg_shared_sel_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              dreq_o,
    output logic              overflow_o
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          sclk_s, sdata_s, dsel_n_s, csel_n_s;
    logic          sel_act;
    logic          byte_vld;
    byte_t         byte_dat;
    logic [CW-1:0] fifo_level;

    sdi_sync #(
        .W      (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk_i, sdata_i, dsel_n_i, csel_n_i}),
        .q    ({sclk_s, sdata_s, dsel_n_s, csel_n_s})
    );

    // Shared mode: data frame is the inverse of the active-low command select
    assign sel_act = cfg_shared_sel_i ? csel_n_s : ~dsel_n_s;

    sdi_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdata_s   (sdata_s),
        .sel_act   (sel_act),
        .fall_edge (cfg_fall_edge_i),
        .lsb_first (cfg_lsb_first_i),
        .byte_vld_o(byte_vld),
        .byte_o    (byte_dat)
    );

    sdi_fifo #(
        .DEPTH (DEPTH),
        .WINDOW(WINDOW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (byte_vld),
        .wr_data_i (byte_dat),
        .rd_i      (rd_en_i),
        .rd_data_o (rd_data_o),
        .rd_valid_o(rd_valid_o),
        .dreq_o    (dreq_o),
        .ovf_o     (overflow_o),
        .level_o   (fifo_level)
    );

endmodule

module sdi_stream_in_chk #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WINDOW = 32,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_act,
    input logic          byte_vld,
    input logic          rd_en,
    input logic [CW-1:0] level,
    input logic          dreq,
    input logic          ovf
);

    a_r5_dreq_window: assert property (@(posedge clk) disable iff (!rst_n)
        dreq == (level <= CW'(DEPTH - WINDOW)));

    a_r4_no_byte_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> !byte_vld);

    a_r6_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && level < CW'(DEPTH) && !rd_en) |=> level == $past(level) + CW'(1));

    a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && level == CW'(DEPTH) && !rd_en) |=> (level == CW'(DEPTH) && ovf));

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !byte_vld) |=> level == '0);

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

endmodule

bind sdi_stream_in sdi_stream_in_chk #(
    .DEPTH (DEPTH),
    .WINDOW(WINDOW)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_act (sel_act),
    .byte_vld(byte_vld),
    .rd_en   (rd_en_i),
    .level   (fifo_level),
    .dreq    (dreq_o),
    .ovf     (overflow_o)
);

// File: tb/test_sdi_stream_in.sv
`timescale 1ns/1ps
module test_sdi_stream_in;

    localparam int DEPTH  = 64;
    localparam int WINDOW = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, sdata = 1'b0, dsel_n = 1'b1, csel_n = 1'b1;
    logic       cfg_fall = 1'b0, cfg_lsb = 1'b0, cfg_shared = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, dreq, ovf;

    sdi_stream_in #(.DEPTH(DEPTH), .WINDOW(WINDOW)) i_sdi_stream_in (
        .clk             (clk),
        .rst_n           (rst_n),
        .sclk_i          (sclk),
        .sdata_i         (sdata),
        .dsel_n_i        (dsel_n),
        .csel_n_i        (csel_n),
        .cfg_fall_edge_i (cfg_fall),
        .cfg_lsb_first_i (cfg_lsb),
        .cfg_shared_sel_i(cfg_shared),
        .rd_en_i         (rd_en),
        .rd_data_o       (rd_data),
        .rd_valid_o      (rd_valid),
        .dreq_o          (dreq),
        .overflow_o      (ovf)
    );

    always #2 clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] q_exp[$];
    bit         m_ovf = 1'b0;
    bit         busy = 1'b1;
    int         quiet = 0;
    bit         done = 1'b0;

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (busy) quiet <= 0;
        else if (quiet < 100) quiet <= quiet + 1;
    end

    // Reference comparison on every clock while the serial side is settled
    always @(negedge clk) begin
        if (rst_n && quiet >= 8) begin
            chk("R5", int'(dreq), int'((DEPTH - q_exp.size()) >= WINDOW), "dreq vs model");
            chk("R10", int'(rd_valid), int'(q_exp.size() != 0), "valid vs model");
            chk("R9", int'(ovf), int'(m_ovf), "overflow vs model");
            if (q_exp.size() != 0) chk("R10", int'(rd_data), int'(q_exp[0]), "head byte vs model");
        end
    end

    task automatic set_sel(bit on);
        @(negedge clk);
        if (cfg_shared) csel_n = on;
        else dsel_n = !on;
        repeat (4) @(negedge clk);
    endtask

    // Data is inverted after the sampling edge so the wrong edge sees junk
    task automatic clock_bit(bit v);
        @(negedge clk);
        sdata = v;
        repeat (3) @(negedge clk);
        sclk = !cfg_fall;
        repeat (3) @(negedge clk);
        sdata = !v;
        repeat (2) @(negedge clk);
        sclk = cfg_fall;
        @(negedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            clock_bit(cfg_lsb ? b[i] : b[7-i]);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        send_bits(b, 8);
        if (q_exp.size() < DEPTH) q_exp.push_back(b);
        else m_ovf = 1'b1;
    endtask

    task automatic settle();
        busy = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk);
        rd_en = 1'b1;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        if (q_exp.size() != 0) void'(q_exp.pop_front());
    endtask

    task automatic pop_chk(string req, logic [7:0] exp);
        @(negedge clk);
        chk(req, int'(rd_valid), 1, "valid before pop");
        chk(req, int'(rd_data), int'(exp), "popped byte");
        pop_one();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL all requirements: watchdog actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", int'(dreq), 1, "dreq after reset");
        chk("R11", int'(rd_valid), 0, "valid after reset");
        chk("R11", int'(ovf), 0, "overflow after reset");
        settle();

        // R3 MSB first on rising edge
        busy = 1'b1;
        set_sel(1);
        send_byte(8'hA5);
        send_byte(8'h3C);
        set_sel(0);
        settle();
        pop_chk("R3", 8'hA5);
        pop_chk("R3", 8'h3C);

        // R3 LSB first
        busy = 1'b1;
        cfg_lsb = 1'b1;
        set_sel(1);
        send_byte(8'h01);
        send_byte(8'hC8);
        set_sel(0);
        settle();
        pop_chk("R3", 8'h01);
        pop_chk("R3", 8'hC8);
        cfg_lsb = 1'b0;

        // R2 falling-edge sampling
        busy = 1'b1;
        cfg_fall = 1'b1;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        set_sel(1);
        send_byte(8'h96);
        set_sel(0);
        cfg_fall = 1'b0;
        sclk = 1'b0;
        settle();
        pop_chk("R2", 8'h96);

        // R1 clocks while deselected form no byte
        busy = 1'b1;
        send_bits(8'hFF, 8);
        settle();
        chk("R1", int'(rd_valid), 0, "byte formed while deselected");

        // R4 partial byte discarded, realigned on reselect
        busy = 1'b1;
        set_sel(1);
        send_bits(8'hFF, 3);
        set_sel(0);
        set_sel(1);
        send_byte(8'h5A);
        set_sel(0);
        settle();
        pop_chk("R4", 8'h5A);
        chk("R4", int'(rd_valid), 0, "stale partial byte stored");

        // R7 shared select: frame is inverse of command select
        busy = 1'b1;
        csel_n = 1'b0;
        repeat (4) @(negedge clk);
        cfg_shared = 1'b1;
        set_sel(1);
        send_byte(8'h77);
        set_sel(0);
        dsel_n = 1'b0;
        repeat (4) @(negedge clk);
        send_bits(8'h11, 8);
        dsel_n = 1'b1;
        settle();
        pop_chk("R7", 8'h77);
        chk("R7", int'(rd_valid), 0, "data select used in shared mode");
        busy = 1'b1;
        cfg_shared = 1'b0;
        csel_n = 1'b1;
        settle();

        // R10 read of empty FIFO ignored
        pop_one();
        repeat (2) @(negedge clk);
        chk("R10", int'(rd_valid), 0, "empty read changed state");

        // R5 threshold, R6 bytes during low dreq, R8 drop, R9 sticky
        busy = 1'b1;
        set_sel(1);
        for (int i = 0; i < WINDOW; i++) send_byte(8'(i * 7 + 3));
        set_sel(0);
        settle();
        chk("R5", int'(dreq), 1, "dreq at exactly 32 bytes");
        busy = 1'b1;
        set_sel(1);
        send_byte(8'hB1);
        set_sel(0);
        settle();
        chk("R5", int'(dreq), 0, "dreq at 33 bytes");
        busy = 1'b1;
        set_sel(1);
        send_byte(8'hB2);
        set_sel(0);
        settle();
        chk("R6", q_exp.size(), 34, "model level");
        busy = 1'b1;
        set_sel(1);
        for (int i = 34; i < DEPTH; i++) send_byte(8'(i * 5 + 1));
        send_byte(8'hEE);
        set_sel(0);
        settle();
        chk("R8", int'(ovf), 1, "overflow after drop");
        for (int i = 0; i < DEPTH; i++) pop_chk("R8", q_exp[0]);
        repeat (3) @(negedge clk);
        chk("R8", int'(rd_valid), 0, "dropped byte appeared");
        chk("R9", int'(ovf), 1, "overflow cleared after drain");
        chk("R5", int'(dreq), 1, "dreq after drain");

        finish_run();
    end

endmodule